// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block translates virtual addresses to physical addresses through a fully associative table of entries. Each entry covers two neighbouring virtual pages, an even page and an odd page, and maps them to two independent physical frames. Every entry carries its own page size, from 1 KB to 256 KB in steps of four. All entries are compared at once on every lookup. A lookup returns a hit flag, the physical address, the cache attribute and the valid and dirty bits of the selected frame, and an exception code.

A miss produces one of two exception codes, picked by the addressing mode of the core (32-bit or 64-bit). A hit on a frame that is not valid produces an invalid-page code. A store to a frame that is valid but clean produces a modified-page code. There is no hardware refill. Software loads entries through a write port and reads them back through a read port.

Top module: `tlb_paired`

## Requirements
- R1: An entry matches when its virtual page-pair number equals `va_i[VA_W-1:11]`, ignoring the low 2*s bits that its page size hides. The entry must also either have its global bit set or have an address-space ID equal to `asid_i`. If neither holds, the entry does not take part.
- R2: Size code s selects a page of 1 KB * 4^s (0=1K, 1=4K, 2=16K, 3=64K, 4=256K). Codes 5 to 7 behave as code 4. The physical address keeps the low 10+2s bits of the virtual address. All bits above them come from the frame number, which is stored in 1 KB units (frame << 10).
- R3: Virtual address bit 10+2s selects the odd frame when 1 and the even frame when 0. The attribute, valid and dirty outputs come from that same frame.
- R4: On a miss, `hit_o`=0, `pa_o`=0 and the attribute, valid and dirty outputs are 0. `exc_o`=1 when `mode64_i`=0 and `exc_o`=2 when `mode64_i`=1.
- R5: On a hit whose selected frame has its valid bit clear, `exc_o`=3. This applies to loads and stores alike.
- R6: On a store (`is_store_i`=1) that hits a valid frame with its dirty bit clear, `exc_o`=4. A load to the same frame gives `exc_o`=0.
- R7: When several entries match, the lowest-index entry supplies the result and `multi_o`=1. With exactly one match, `multi_o`=0.
- R8: Results appear on the clock edge after `lookup_vld_i` is sampled, with `res_vld_o`=1. In a cycle without a lookup, `res_vld_o`=0 and the result outputs hold their values.
- R9: `wr_en_i` loads `wr_data_i` into entry `wr_idx_i` at the clock edge. The layout from MSB to LSB is {size[2:0], vpn2[20:0], asid[7:0], global, pfn_odd[21:0], v_odd, d_odd, attr_odd[2:0], pfn_even[21:0], v_even, d_even, attr_even[2:0]}. A lookup sampled at that same edge sees the old contents. Later lookups see the new contents.
- R10: `rd_data_o` presents the entry at `rd_idx_i`, in the R9 layout, one clock edge after `rd_idx_i` is sampled.
- R11: Reset clears every entry to all zeros and clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_vld_i | input | 1 | Lookup request |
| va_i | input | VA_W | Virtual address |
| asid_i | input | ASID_W | Current address-space ID |
| is_store_i | input | 1 | Lookup is for a store |
| mode64_i | input | 1 | Core is in 64-bit addressing mode |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_data_i | input | ENTRY_W | Entry contents (R9 layout) |
| rd_idx_i | input | IDX_W | Entry index to read |
| rd_data_o | output | ENTRY_W | Entry contents read back |
| res_vld_o | output | 1 | Result valid |
| hit_o | output | 1 | Some entry matched |
| multi_o | output | 1 | More than one entry matched |
| exc_o | output | 3 | Exception code (0 none, 1 miss, 2 64-bit miss, 3 invalid, 4 modified) |
| pa_o | output | PA_W | Physical address |
| attr_o | output | 3 | Cache attribute of the selected frame |
| valid_o | output | 1 | Valid bit of the selected frame |
| dirty_o | output | 1 | Dirty bit of the selected frame |

## Verification
A write and a lookup can land on the same entry in the same cycle. The bench drives both strobes at one edge, with the lookup address inside the page pair being rewritten. It expects the lookup to return the translation from before the write. A second lookup one cycle later must return the new frame. Around this case, every entry is loaded with a different page size, including a clamped size code. Both halves of every entry are then probed with loads and stores, with matching and mismatching address-space IDs, and in both addressing modes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_SHIFT = 10;
  localparam logic [2:0] SZ_MAX = 3'd4;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_MISS  = 3'd1,
    EXC_XMISS = 3'd2,
    EXC_INV   = 3'd3,
    EXC_MOD   = 3'd4
  } exc_e;

  function automatic logic [2:0] clamp_size(input logic [2:0] s);
    return (s > SZ_MAX) ? SZ_MAX : s;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int NUM_ENTRIES = 32,
  parameter int ENTRY_W     = 87,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  wr_en_i,
  input  logic [IDX_W-1:0]                      wr_idx_i,
  input  logic [ENTRY_W-1:0]                    wr_data_i,
  input  logic [IDX_W-1:0]                      rd_idx_i,
  output logic [ENTRY_W-1:0]                    rd_data_o,
  output logic [NUM_ENTRIES-1:0][ENTRY_W-1:0]   ent_o
);
  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q     <= '0;
      rd_data_o <= '0;
    end else begin
      if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
      rd_data_o <= mem_q[rd_idx_i];
    end
  end

  assign ent_o = mem_q;
endmodule

// File: rtl/tlb_cmp.sv
module tlb_cmp import tlb_pkg::*; #(
  parameter int VPN2_W = 21,
  parameter int ASID_W = 8
) (
  input  logic [VPN2_W-1:0] va_vpn2_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [2:0]        e_size_i,
  input  logic [VPN2_W-1:0] e_vpn2_i,
  input  logic [ASID_W-1:0] e_asid_i,
  input  logic              e_g_i,
  output logic              hit_o
);
  logic [2:0]        sz;
  logic [VPN2_W-1:0] keep;

  always_comb begin
    sz    = clamp_size(e_size_i);
    keep  = {VPN2_W{1'b1}} << {sz, 1'b0};
    hit_o = (((va_vpn2_i ^ e_vpn2_i) & keep) == '0) && (e_g_i || (e_asid_i == asid_i));
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int NUM_ENTRIES = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] match_i,
  output logic [IDX_W-1:0]       win_o,
  output logic                   any_o,
  output logic                   multi_o
);
  always_comb begin
    win_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) win_o = IDX_W'(i);
    end
    any_o   = |match_i;
    // more than one bit set
    multi_o = |(match_i & (match_i - NUM_ENTRIES'(1)));
  end
endmodule

// File: rtl/tlb_paired.sv
module tlb_paired import tlb_pkg::*; #(
  parameter int NUM_ENTRIES = 32,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int ASID_W      = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int VPN2_W     = VA_W - PAGE_SHIFT - 1,
  localparam int PFN_W      = PA_W - PAGE_SHIFT,
  localparam int ENTRY_W    = 3 + VPN2_W + ASID_W + 1 + 2 * (PFN_W + 5)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lookup_vld_i,
  input  logic [VA_W-1:0]    va_i,
  input  logic [ASID_W-1:0]  asid_i,
  input  logic               is_store_i,
  input  logic               mode64_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic               res_vld_o,
  output logic               hit_o,
  output logic               multi_o,
  output logic [2:0]         exc_o,
  output logic [PA_W-1:0]    pa_o,
  output logic [2:0]         attr_o,
  output logic               valid_o,
  output logic               dirty_o
);
  localparam int C0_LO   = 0;
  localparam int D0_B    = 3;
  localparam int V0_B    = 4;
  localparam int PFN0_LO = 5;
  localparam int C1_LO   = PFN0_LO + PFN_W;
  localparam int D1_B    = C1_LO + 3;
  localparam int V1_B    = D1_B + 1;
  localparam int PFN1_LO = V1_B + 1;
  localparam int G_B     = PFN1_LO + PFN_W;
  localparam int ASID_LO = G_B + 1;
  localparam int VPN_LO  = ASID_LO + ASID_W;
  localparam int SZ_LO   = VPN_LO + VPN2_W;

  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] ent;
  logic [NUM_ENTRIES-1:0]              match;
  logic [IDX_W-1:0]                    win;
  logic                                any_hit, multi_c;

  tlb_store #(.NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i, .rd_idx_i, .rd_data_o,
    .ent_o(ent)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    tlb_cmp #(.VPN2_W(VPN2_W), .ASID_W(ASID_W)) u_cmp (
      .va_vpn2_i(va_i[VA_W-1:PAGE_SHIFT+1]),
      .asid_i,
      .e_size_i(ent[e][SZ_LO+:3]),
      .e_vpn2_i(ent[e][VPN_LO+:VPN2_W]),
      .e_asid_i(ent[e][ASID_LO+:ASID_W]),
      .e_g_i(ent[e][G_B]),
      .hit_o(match[e])
    );
  end

  tlb_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
    .match_i(match), .win_o(win), .any_o(any_hit), .multi_o(multi_c)
  );

  logic [2:0]       sz;
  logic [7:0]       sh;
  logic             odd;
  logic [PA_W-1:0]  off, pa_c;
  logic [PFN_W-1:0] pfn;
  logic             v_c, d_c;
  logic [2:0]       attr_c;
  exc_e             exc_c;

  always_comb begin
    sz   = clamp_size(ent[win][SZ_LO+:3]);
    sh   = 8'(PAGE_SHIFT) + {4'd0, sz, 1'b0};
    odd  = |(va_i & (VA_W'(1) << sh));
    off  = ~({PA_W{1'b1}} << sh);
    if (odd) begin
      pfn    = ent[win][PFN1_LO+:PFN_W];
      v_c    = ent[win][V1_B];
      d_c    = ent[win][D1_B];
      attr_c = ent[win][C1_LO+:3];
    end else begin
      pfn    = ent[win][PFN0_LO+:PFN_W];
      v_c    = ent[win][V0_B];
      d_c    = ent[win][D0_B];
      attr_c = ent[win][C0_LO+:3];
    end
    pa_c = ({pfn, {PAGE_SHIFT{1'b0}}} & ~off) | (PA_W'(va_i) & off);
    if (!any_hit) begin
      exc_c  = mode64_i ? EXC_XMISS : EXC_MISS;
      pa_c   = '0;
      v_c    = 1'b0;
      d_c    = 1'b0;
      attr_c = '0;
    end else if (!v_c)                 exc_c = EXC_INV;
    else if (is_store_i && !d_c)       exc_c = EXC_MOD;
    else                               exc_c = EXC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o <= 1'b0;
      hit_o     <= 1'b0;
      multi_o   <= 1'b0;
      exc_o     <= '0;
      pa_o      <= '0;
      attr_o    <= '0;
      valid_o   <= 1'b0;
      dirty_o   <= 1'b0;
    end else begin
      res_vld_o <= lookup_vld_i;
      if (lookup_vld_i) begin
        hit_o   <= any_hit;
        multi_o <= multi_c;
        exc_o   <= exc_c;
        pa_o    <= pa_c;
        attr_o  <= attr_c;
        valid_o <= v_c;
        dirty_o <= d_c;
      end
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk import tlb_pkg::*; #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lookup_vld_i,
  input logic [VA_W-1:0] va_i,
  input logic            is_store_i,
  input logic            mode64_i,
  input logic            res_vld_o,
  input logic            hit_o,
  input logic            multi_o,
  input logic [2:0]      exc_o,
  input logic [PA_W-1:0] pa_o,
  input logic            valid_o,
  input logic            dirty_o
);
  // R8
  vld_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_vld_i |=> res_vld_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_vld_i |=> !res_vld_o && $stable(pa_o) && $stable(exc_o) && $stable(hit_o));

  // R7
  multi_has_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> hit_o);

  // R4
  miss_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o && !hit_o |->
      (exc_o == ($past(mode64_i) ? 3'(EXC_XMISS) : 3'(EXC_MISS))) && (pa_o == '0));

  // R2
  offset_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o && hit_o |-> pa_o[PAGE_SHIFT-1:0] == $past(va_i[PAGE_SHIFT-1:0]));

  // R5
  invalid_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o && hit_o && !valid_o |-> exc_o == 3'(EXC_INV));

  // R6
  modified_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o && exc_o == 3'(EXC_MOD) |-> $past(is_store_i) && valid_o && !dirty_o);
endmodule

bind tlb_paired tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk_i, .rst_ni, .lookup_vld_i, .va_i, .is_store_i, .mode64_i,
  .res_vld_o, .hit_o, .multi_o, .exc_o, .pa_o, .valid_o, .dirty_o
);

// File: tb/tb_tlb_paired.sv
`timescale 1ns/1ps
module tb_tlb_paired;
  localparam int N = 32, VW = 32, PW = 32, AW = 8;
  localparam int VPN2_W = 21, PFN_W = 22, EW = 87;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          lookup_vld = 0, is_store = 0, mode64 = 0, wr_en = 0;
  logic [VW-1:0] va = '0;
  logic [AW-1:0] asid = '0;
  logic [4:0]    wr_idx = '0, rd_idx = '0;
  logic [EW-1:0] wr_data = '0, rd_data;
  logic          res_vld, hit, multi, valid, dirty;
  logic [2:0]    exc, attr;
  logic [PW-1:0] pa;

  int n_chk = 0, n_bad = 0;

  // bench model of the table
  logic [2:0]        m_size [N];
  logic [VPN2_W-1:0] m_vpn2 [N];
  logic [AW-1:0]     m_asid [N];
  logic              m_g    [N];
  logic [PFN_W-1:0]  m_pfn  [N][2];
  logic              m_v    [N][2];
  logic              m_d    [N][2];
  logic [2:0]        m_c    [N][2];

  always #4 clk = ~clk;

  tlb_paired dut (
    .clk_i(clk), .rst_ni(rst_n), .lookup_vld_i(lookup_vld), .va_i(va), .asid_i(asid),
    .is_store_i(is_store), .mode64_i(mode64), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .res_vld_o(res_vld),
    .hit_o(hit), .multi_o(multi), .exc_o(exc), .pa_o(pa), .attr_o(attr),
    .valid_o(valid), .dirty_o(dirty)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] pack(input int i);
    return {m_size[i], m_vpn2[i], m_asid[i], m_g[i],
            m_pfn[i][1], m_v[i][1], m_d[i][1], m_c[i][1],
            m_pfn[i][0], m_v[i][0], m_d[i][0], m_c[i][0]};
  endfunction

  function automatic int sz_of(input int i);
    return (m_size[i] > 3'd4) ? 4 : int'(m_size[i]);
  endfunction

  // expected vector {vld,hit,multi,exc,valid,dirty,attr,pa}
  function automatic logic [42:0] predict(input logic [31:0] a, input logic [7:0] as,
                                          input logic st, input logic m64);
    logic h, mu, o, v, d;
    logic [2:0] e, c;
    logic [31:0] p, off;
    logic [20:0] keep;
    int w, s;
    h = 0; mu = 0; w = 0;
    for (int i = 0; i < N; i++) begin
      s = sz_of(i);
      keep = ~((21'd1 << (2 * s)) - 21'd1);
      if ((((a[31:11] ^ m_vpn2[i]) & keep) == '0) && (m_g[i] || m_asid[i] == as)) begin
        if (h) mu = 1; else begin h = 1; w = i; end
      end
    end
    if (!h) return {1'b1, 1'b0, 1'b0, (m64 ? 3'd2 : 3'd1), 1'b0, 1'b0, 3'd0, 32'd0};
    s = sz_of(w);
    o = a[10 + 2 * s];
    off = (32'd1 << (10 + 2 * s)) - 32'd1;
    p = (({10'd0, m_pfn[w][o]} << 10) & ~off) | (a & off);
    v = m_v[w][o]; d = m_d[w][o]; c = m_c[w][o];
    e = !v ? 3'd3 : (st && !d) ? 3'd4 : 3'd0;
    return {1'b1, 1'b1, mu, e, v, d, c, p};
  endfunction

  function automatic string cls(input logic [42:0] x);
    if (!x[41]) return "R4";
    if (x[40]) return "R7";
    if (x[39:37] == 3'd3) return "R5";
    if (x[39:37] == 3'd4) return "R6";
    return "ok";
  endfunction

  task automatic probe(input logic [31:0] a, input logic [7:0] as, input logic st,
                       input logic m64, input string tag);
    logic [42:0] ex;
    ex = predict(a, as, st, m64);
    @(negedge clk);
    va = a; asid = as; is_store = st; mode64 = m64; lookup_vld = 1;
    @(negedge clk);
    lookup_vld = 0;
    chk({res_vld, hit, multi, exc, valid, dirty, attr, pa} === ex,
        $sformatf("%s/%s", tag, cls(ex)), $sformatf("lookup va=%h", a),
        128'({res_vld, hit, multi, exc, valid, dirty, attr, pa}), 128'(ex));
  endtask

  task automatic load(input int i);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(i); wr_data = pack(i);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic gen(input int i);
    m_size[i]   = (i == 29) ? 3'd6 : 3'(i % 5);
    m_vpn2[i]   = 21'((i + 1) << 8);
    m_asid[i]   = 8'(i + 16);
    m_g[i]      = (i % 3 == 0);
    m_pfn[i][0] = 22'((i << 12) | 'h2A5);
    m_pfn[i][1] = 22'((i << 12) | 'h15A);
    m_v[i][0]   = 1'b1;
    m_v[i][1]   = (i % 4 != 1);
    m_d[i][0]   = 1'(i % 2);
    m_d[i][1]   = 1'b1;
    m_c[i][0]   = 3'(i % 8);
    m_c[i][1]   = 3'((i + 3) % 8);
  endtask

  function automatic logic [31:0] addr_of(input int i, input int odd, input logic [31:0] salt);
    int s;
    logic [31:0] off;
    s = sz_of(i);
    off = (32'd1 << (10 + 2 * s)) - 32'd1;
    return ({11'd0, m_vpn2[i]} << 11) | (32'(odd) << (10 + 2 * s)) | (salt & off);
  endfunction

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_size[i] = 0; m_vpn2[i] = 0; m_asid[i] = 0; m_g[i] = 0;
      for (int h = 0; h < 2; h++) begin
        m_pfn[i][h] = 0; m_v[i][h] = 0; m_d[i][h] = 0; m_c[i][h] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: outputs cleared, table cleared
    chk({res_vld, hit, multi, exc, valid, dirty, attr, pa} === '0, "R11", "outputs after reset",
        128'({res_vld, hit, multi, exc, pa}), 128'(0));
    chk(rd_data === '0, "R11", "entry 0 after reset", 128'(rd_data), 128'(0));
    // R11: all-zero entries all match va 0 / asid 0, invalid frames
    probe(32'h0000_0123, 8'd0, 1'b0, 1'b0, "R11");
    probe(32'h0000_0123, 8'd5, 1'b0, 1'b1, "R11");

    for (int i = 0; i < N; i++) begin
      gen(i);
      load(i);
    end
    // R10: read back every entry in the R9 layout
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      rd_idx = 5'(i);
      @(negedge clk);
      chk(rd_data === pack(i), "R10", $sformatf("readback %0d", i), 128'(rd_data), 128'(pack(i)));
    end

    // R1 R2 R3: both halves of every entry, every size, loads and stores, both modes
    for (int i = 0; i < N; i++) begin
      for (int odd = 0; odd < 2; odd++) begin
        for (int st = 0; st < 2; st++) begin
          probe(addr_of(i, odd, 32'h2D3B_7A19 + 32'(i * 977)), m_asid[i], 1'(st), 1'(odd),
                odd ? "R3" : "R2");
        end
        // R1: wrong address-space ID, hits only when global
        probe(addr_of(i, odd, 32'h0001_5C3F), m_asid[i] + 8'd1, 1'b0, 1'(st_mode(i)), "R1");
      end
    end

    // R4: unmapped region in both modes
    probe(32'hF800_0400, 8'd3, 1'b0, 1'b0, "R4");
    probe(32'hF800_0400, 8'd3, 1'b1, 1'b1, "R4");
    // R1: masked page-number bits ignored, unmasked bit just above changes the result
    probe(addr_of(4, 1, 32'h0003_FFFF), m_asid[4], 1'b0, 1'b0, "R1");
    probe(addr_of(4, 0, 0) ^ (32'd1 << 19), m_asid[4], 1'b0, 1'b0, "R1");

    // R7: entry 31 overlays entry 4 (size 4, non-global) as a global mapping
    m_size[31] = m_size[4]; m_vpn2[31] = m_vpn2[4]; m_g[31] = 1'b1;
    m_pfn[31][0] = 22'h3F_0000; m_pfn[31][1] = 22'h3E_0000;
    load(31);
    probe(addr_of(4, 0, 32'h1234), m_asid[4], 1'b0, 1'b0, "R7");
    probe(addr_of(4, 1, 32'h1234), m_asid[4], 1'b1, 1'b0, "R7");
    probe(addr_of(4, 0, 32'h1234), 8'hEE, 1'b0, 1'b0, "R7");

    // R9: write and lookup of entry 10 in the same cycle
    begin
      logic [42:0] ex_old, ex_new;
      logic [31:0] a;
      a = addr_of(10, 0, 32'h0ABC);
      ex_old = predict(a, m_asid[10], 1'b0, 1'b0);
      m_pfn[10][0] = 22'h2A_AAAA;
      ex_new = predict(a, m_asid[10], 1'b0, 1'b0);
      @(negedge clk);
      wr_en = 1; wr_idx = 5'd10; wr_data = pack(10);
      va = a; asid = m_asid[10]; is_store = 0; mode64 = 0; lookup_vld = 1;
      @(negedge clk);
      wr_en = 0; lookup_vld = 0;
      chk({res_vld, hit, multi, exc, valid, dirty, attr, pa} === ex_old, "R9", "same-cycle lookup",
          128'(pa), 128'(ex_old[31:0]));
      probe(a, m_asid[10], 1'b0, 1'b0, "R9");
      chk(ex_new[31:0] != ex_old[31:0], "R9", "new frame differs", 128'(ex_new[31:0]), 128'(ex_old[31:0]));
    end

    // R8: idle cycle clears result valid and holds result
    begin
      logic [31:0] pa_keep;
      pa_keep = pa;
      @(negedge clk);
      chk(res_vld === 1'b0 && pa === pa_keep, "R8", "idle hold",
          128'({res_vld, pa}), 128'({1'b0, pa_keep}));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic int st_mode(input int i);
    return i % 2;
  endfunction
endmodule